// File: doc/BRIEF.md
# Critical-Word-First Refill Controller

This block runs the refill of one cache line after a miss. It takes a miss request made of a block address and a word offset. It asks memory for the block and writes the returned words into a line buffer and the cache data array. The word the processor asked for goes back to the processor as soon as it arrives. The processor therefore resumes while the rest of the line is still streaming in.

A mode input chooses the fetch order, and it is sampled when the miss is taken. In critical-word-first mode the block is requested from the missed word onward and wraps around the block boundary. In early-restart mode the block comes back from word 0 in natural order, and the processor is released at the beat that carries its word.

While a fill is in flight, the processor may ask again for the same block. If the word is already in the line buffer, it is answered from there. Any other request waits until the controller is idle again. Tag handling and memory timing lie outside the block.

Top module: `cwf_refill_ctrl`

## Requirements
- R1: After reset, `miss_ready` is 1 and `mem_req_valid`, `cpu_rvalid`, `line_we` and `line_done` are 0.
- R2: A new miss is taken only while idle. While a fill is busy, `miss_ready` stays 0 for a request to another block or to a word of the filling block not yet received.
- R3: The cycle after a miss is taken, `mem_req_valid` is high for exactly one cycle. It carries the block address and the start word. The start word is the missed offset when `cwf_mode`=1 and 0 when `cwf_mode`=0, with `cwf_mode` sampled only at acceptance.
- R4: Beat i of the fill (counting only cycles with `mem_rvalid` high while filling) holds word (start+i) mod 8. One cycle after each beat, `line_we` is 1 with that word index and data.
- R5: `cpu_rvalid` is 1 for one cycle, the cycle after the beat that carries the missed word, with that beat's data. It does not wait for the remaining words of the line.
- R6: In early-restart mode, exactly k line writes (words 0 to k-1) come before the processor release for missed offset k. In critical-word-first mode, none come before it.
- R7: `line_done` pulses once per fill, in the cycle after the eighth line write.
- R8: While busy, a request to the filling block for a word already received is accepted (`miss_ready`=1). It is answered the next cycle with `cpu_rvalid` and the buffered word.
- R9: When such a buffer hit coincides with the beat carrying the missed word, the forward of the missed word wins. The hit is held off for that cycle.
- R10: `mem_rvalid` while idle has no effect: no line write and no processor return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cwf_mode | input | 1 | 1 = critical word first, 0 = early restart |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Request accepted this cycle when valid |
| miss_block | input | BLK_W | Block address of the request |
| miss_offset | input | OFF_W | Word offset inside the block |
| mem_req_valid | output | 1 | One-cycle block fetch request |
| mem_req_block | output | BLK_W | Block to fetch |
| mem_req_start | output | OFF_W | First word memory must return |
| mem_rvalid | input | 1 | Memory word beat valid |
| mem_rdata | input | WORD_W | Memory word beat data |
| cpu_rvalid | output | 1 | Data return to processor |
| cpu_rdata | output | WORD_W | Returned word |
| line_we | output | 1 | Cache data array word write |
| line_idx | output | OFF_W | Word index of the write |
| line_wdata | output | WORD_W | Word written |
| line_block | output | BLK_W | Block being filled |
| line_done | output | 1 | Line complete, may be marked valid |

## Verification
Fills run with both back-to-back and gapped memory beats. Missed offsets are 0, a middle word and 7, which puts the critical word at the start, the middle and the wrap point of the block. Running the same offsets in both modes separates the wrapped order from the natural order, and the count of writes before release tells the two release points apart. Second requests during a fill go to a foreign block, to an unreceived word, to a received word, and to a received word in the same cycle as the critical beat. These four cases cover stall, hit and the priority of the forward.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_REQUEST = 2'd1,
    ST_FILL    = 2'd2,
    ST_DONE    = 2'd3
  } refill_state_e;
endpackage

// File: rtl/refill_order_gen.sv
// Beat sequencer: word index of the current beat, wrapping at the block end.
module refill_order_gen #(
  parameter int WORDS = 8,
  parameter int OFF_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OFF_W-1:0] start_off,
  input  logic             advance,
  output logic [OFF_W-1:0] cur_idx,
  output logic             last_beat
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(WORDS - 1);

  logic [OFF_W-1:0] beat_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_idx  <= '0;
      beat_cnt <= '0;
    end else if (load) begin
      cur_idx  <= start_off;
      beat_cnt <= '0;
    end else if (advance) begin
      cur_idx  <= (cur_idx == LAST) ? '0 : cur_idx + 1'b1;
      beat_cnt <= (beat_cnt == LAST) ? '0 : beat_cnt + 1'b1;
    end
  end

  assign last_beat = (beat_cnt == LAST);
endmodule

// File: rtl/refill_line_buf.sv
// Line buffer: word storage with synchronous read plus a per-word received mask.
module refill_line_buf #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  parameter int OFF_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [OFF_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data,
  output logic [WORDS-1:0]  filled
);
  logic [WORD_W-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_data;
    if (rd_en) rd_data <= store[rd_idx];
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst || clear)
        filled[g] <= 1'b0;
      else if (wr_en && wr_idx == OFF_W'(g))
        filled[g] <= 1'b1;
    end
  end

  // R8: a buffer read only ever targets a word already received
  a_r8_read_filled: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> filled[rd_idx]);
endmodule

// File: rtl/cwf_refill_ctrl.sv
module cwf_refill_ctrl #(
  parameter int BLK_W  = 26,
  parameter int WORD_W = 32,
  parameter int WORDS  = 8,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cwf_mode,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [BLK_W-1:0]  miss_block,
  input  logic [OFF_W-1:0]  miss_offset,
  output logic              mem_req_valid,
  output logic [BLK_W-1:0]  mem_req_block,
  output logic [OFF_W-1:0]  mem_req_start,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              cpu_rvalid,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              line_we,
  output logic [OFF_W-1:0]  line_idx,
  output logic [WORD_W-1:0] line_wdata,
  output logic [BLK_W-1:0]  line_block,
  output logic              line_done
);
  import refill_pkg::*;

  refill_state_e     st;
  logic [BLK_W-1:0]  blk_q;
  logic [OFF_W-1:0]  crit_q;
  logic [OFF_W-1:0]  start_q;
  logic [OFF_W-1:0]  ord_idx;
  logic              ord_last;
  logic [WORDS-1:0]  filled;
  logic [WORD_W-1:0] buf_rd;
  logic [WORD_W-1:0] crit_data_q;
  logic              cpu_src_q;

  logic             busy, accept_new, beat, crit_beat, same_blk, hit_ok, buf_hit;
  logic [OFF_W-1:0] start_sel;

  assign busy       = (st != ST_IDLE);
  assign accept_new = (st == ST_IDLE) && miss_valid;
  assign beat       = (st == ST_FILL) && mem_rvalid;
  assign crit_beat  = beat && (ord_idx == crit_q);
  assign same_blk   = (miss_block == blk_q);
  assign hit_ok     = busy && same_blk && filled[miss_offset] && !crit_beat;
  assign buf_hit    = miss_valid && hit_ok;
  assign miss_ready = (st == ST_IDLE) || hit_ok;
  assign start_sel  = cwf_mode ? miss_offset : '0;

  refill_order_gen #(.WORDS(WORDS), .OFF_W(OFF_W)) u_order (
    .clk       (clk),
    .rst       (rst),
    .load      (accept_new),
    .start_off (start_sel),
    .advance   (beat),
    .cur_idx   (ord_idx),
    .last_beat (ord_last)
  );

  refill_line_buf #(.WORDS(WORDS), .WORD_W(WORD_W), .OFF_W(OFF_W)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .clear   (accept_new),
    .wr_en   (beat),
    .wr_idx  (ord_idx),
    .wr_data (mem_rdata),
    .rd_en   (buf_hit),
    .rd_idx  (miss_offset),
    .rd_data (buf_rd),
    .filled  (filled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE:    if (miss_valid) st <= ST_REQUEST;
        ST_REQUEST: st <= ST_FILL;
        ST_FILL:    if (beat && ord_last) st <= ST_DONE;
        default:    st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q   <= '0;
      crit_q  <= '0;
      start_q <= '0;
    end else if (accept_new) begin
      blk_q   <= miss_block;
      crit_q  <= miss_offset;
      start_q <= start_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rvalid  <= 1'b0;
      cpu_src_q   <= 1'b0;
      crit_data_q <= '0;
      line_we     <= 1'b0;
      line_idx    <= '0;
      line_wdata  <= '0;
      line_done   <= 1'b0;
    end else begin
      cpu_rvalid <= crit_beat || buf_hit;
      if (crit_beat) begin
        cpu_src_q   <= 1'b0;
        crit_data_q <= mem_rdata;
      end else if (buf_hit) begin
        cpu_src_q <= 1'b1;
      end
      line_we <= beat;
      if (beat) begin
        line_idx   <= ord_idx;
        line_wdata <= mem_rdata;
      end
      line_done <= (st == ST_DONE);
    end
  end

  assign cpu_rdata     = cpu_src_q ? buf_rd : crit_data_q;
  assign mem_req_valid = (st == ST_REQUEST);
  assign mem_req_block = blk_q;
  assign mem_req_start = start_q;
  assign line_block    = blk_q;

  // R3: fetch request lasts one cycle and follows an accepted idle miss
  a_r3_req_one_cycle: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);
  a_r3_req_after_accept: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> $past(miss_valid && miss_ready && st == ST_IDLE));
  // R2: a foreign block is never accepted while a fill is busy
  a_r2_hold_foreign: assert property (@(posedge clk) disable iff (rst)
    (busy && miss_valid && !same_blk) |-> !miss_ready);
  // R4 / R10: a line write only follows a beat taken while filling
  a_r4_we_from_fill: assert property (@(posedge clk) disable iff (rst)
    line_we |-> $past(st == ST_FILL && mem_rvalid));
  // R7: completion comes straight after a line write
  a_r7_done_after_write: assert property (@(posedge clk) disable iff (rst)
    line_done |-> $past(line_we));
  // R5: forwarded word equals the beat seen one cycle earlier
  a_r5_crit_data: assert property (@(posedge clk) disable iff (rst)
    (cpu_rvalid && !cpu_src_q) |-> cpu_rdata == $past(mem_rdata));
endmodule

// File: tb/cwf_refill_ctrl_test.sv
module cwf_refill_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cwf_mode = 1'b1;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [25:0] miss_block = '0;
  logic [2:0]  miss_offset = '0;
  logic        mem_req_valid;
  logic [25:0] mem_req_block;
  logic [2:0]  mem_req_start;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        line_we;
  logic [2:0]  line_idx;
  logic [31:0] line_wdata;
  logic [25:0] line_block;
  logic        line_done;

  cwf_refill_ctrl uut (.*);

  always #5 clk = ~clk;

  int    checks = 0, failures = 0, cycles = 0;
  string scn = "reset";

  // behavioural reference state
  int          mst = 0, beats = 0, koff = 0, mstart = 0;
  logic [25:0] mblk = '0;
  bit   [7:0]  mfill = '0;
  logic [31:0] mbuf [8];
  bit          e_req = 0, e_cpu = 0, e_we = 0, e_done = 0;
  logic [31:0] e_cpud = '0, e_wd = '0;
  int          e_idx = 0, we_cnt = 0;
  bit          cpu_seen = 0;

  function automatic logic [31:0] wdata(input logic [25:0] b, input int w);
    return 32'(b * 8 + w) ^ 32'hA5C3_0000;
  endfunction

  function automatic bit model_ready();
    bit crit;
    crit = (mst == 2) && mem_rvalid && ((mstart + beats) % 8 == koff);
    return (mst == 0) ||
           (miss_block == mblk && mfill[miss_offset] && !crit);
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s [%s] actual=%h expected=%h", tag, what, scn, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      failures++;
      $display("FAIL watchdog expired [%s]", scn);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      mst = 0; e_req = 0; e_cpu = 0; e_we = 0; e_done = 0;
    end else begin
      bit r;
      r = model_ready();
      e_cpu = 0; e_we = 0; e_done = (mst == 3);
      if (mst == 0) begin
        if (miss_valid) begin
          mblk = miss_block; koff = int'(miss_offset);
          mstart = cwf_mode ? koff : 0;
          mfill = '0; beats = 0; mst = 1;
        end
      end else begin
        if (miss_valid && r) begin e_cpu = 1; e_cpud = mbuf[miss_offset]; end
        if (mst == 1) mst = 2;
        else if (mst == 2) begin
          if (mem_rvalid) begin
            int w;
            w = (mstart + beats) % 8;
            mbuf[w] = mem_rdata; mfill[w] = 1'b1;
            e_we = 1; e_idx = w; e_wd = mem_rdata;
            if (w == koff) begin e_cpu = 1; e_cpud = mem_rdata; end
            beats++;
            if (beats == 8) mst = 3;
          end
        end else mst = 0;
      end
      e_req = (mst == 1);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R2", "miss_ready", 64'(miss_ready), 64'(model_ready()));
      check("R3", "mem_req_valid", 64'(mem_req_valid), 64'(e_req));
      if (e_req) begin
        check("R3", "mem_req_block", 64'(mem_req_block), 64'(mblk));
        check("R3", "mem_req_start", 64'(mem_req_start), 64'(mstart));
      end
      check("R5", "cpu_rvalid", 64'(cpu_rvalid), 64'(e_cpu));
      if (e_cpu) check("R5", "cpu_rdata", 64'(cpu_rdata), 64'(e_cpud));
      check("R4", "line_we", 64'(line_we), 64'(e_we));
      if (e_we) begin
        check("R4", "line_idx", 64'(line_idx), 64'(e_idx));
        check("R4", "line_wdata", 64'(line_wdata), 64'(e_wd));
      end
      check("R7", "line_done", 64'(line_done), 64'(e_done));
      if (mem_req_valid) begin we_cnt = 0; cpu_seen = 0; end
      if (cpu_rvalid && !cpu_seen) begin
        cpu_seen = 1;
        check("R6", "writes before release", 64'(we_cnt), 64'((koff - mstart + 8) % 8));
      end
      if (line_we) we_cnt++;
    end
  end

  task automatic issue_hold(input logic [25:0] b, input int off, input int n);
    @(posedge clk); #2;
    miss_valid = 1'b1; miss_block = b; miss_offset = 3'(off);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (miss_ready) break;
    end
    @(posedge clk); #2;
    miss_valid = 1'b0;
  endtask

  task automatic fill(input string s, input logic [25:0] b, input int off,
                      input bit mode, input bit gap, input bit hb_en,
                      input int hb_at, input logic [25:0] hb_blk,
                      input int hb_off, input int hb_hold);
    int st0;
    scn = s;
    cwf_mode = mode;
    st0 = mode ? off : 0;
    issue_hold(b, off, 4);
    cwf_mode = !mode; // R3: later mode changes must not alter this fill
    fork
      begin
        @(posedge clk); #2;
        for (int i = 0; i < 8; i++) begin
          if (gap && (i % 2 == 1)) begin
            mem_rvalid = 1'b0;
            @(posedge clk); #2;
          end
          mem_rvalid = 1'b1;
          mem_rdata  = wdata(b, (st0 + i) % 8);
          @(posedge clk); #2;
        end
        mem_rvalid = 1'b0;
      end
      begin
        if (hb_en) begin
          repeat (hb_at) @(posedge clk);
          issue_hold(hb_blk, hb_off, hb_hold);
        end
      end
    join
    repeat (4) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    scn = "R1 reset";
    check("R1", "miss_ready", 64'(miss_ready), 64'd1);
    check("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
    check("R1", "cpu_rvalid", 64'(cpu_rvalid), 64'd0);
    check("R1", "line_we", 64'(line_we), 64'd0);
    check("R1", "line_done", 64'(line_done), 64'd0);

    fill("R5 cwf mid offset",        26'h0123, 5, 1, 0, 0, 0, '0, 0, 0);
    fill("R4 cwf offset 0 gapped",   26'h0456, 0, 1, 1, 0, 0, '0, 0, 0);
    fill("R6 early restart gapped",  26'h0789, 6, 0, 1, 0, 0, '0, 0, 0);
    fill("R8 hit after wrap",        26'h0ABC, 7, 1, 0, 1, 3, 26'h0ABC, 0, 4);
    fill("R2 foreign block stalls",  26'h0DEF, 2, 1, 0, 1, 2, 26'h0111, 1, 3);
    fill("R2 unfilled word stalls",  26'h0222, 2, 1, 0, 1, 1, 26'h0222, 7, 2);
    fill("R9 hit meets critical",    26'h0333, 5, 0, 0, 1, 5, 26'h0333, 2, 4);
    fill("R6 early restart off 0",   26'h0444, 0, 0, 0, 0, 0, '0, 0, 0);

    scn = "R10 idle beats ignored";
    @(posedge clk); #2;
    mem_rvalid = 1'b1; mem_rdata = 32'hDEAD_BEEF;
    repeat (3) @(posedge clk);
    #2 mem_rvalid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", "line_we idle", 64'(line_we), 64'd0);
    check("R10", "cpu_rvalid idle", 64'(cpu_rvalid), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule